// File: doc/BRIEF.md
# Address Section Permission Guard

This block decides whether each bus access may proceed. Three programmable boundary addresses split the address space. Addresses below the first boundary, or at or above the third, form a reject section. The span from the first boundary up to the second is section 1. The span from the second boundary up to the third is section 2. Section 1 and section 2 each have a six-bit attribute. The attribute holds read, write and execute grants for each of two security worlds. The block returns an allow or fault verdict one cycle after each request.

Configuration goes through a write port. The three boundaries are written together as one set, and a set that is out of order is refused with an error pulse. The two attributes are written together as a pair. A lock input freezes the configuration, and only reset releases it. One instance guards the instruction bus and a second instance guards the data bus.

Top module: `addr_perm_guard`

## Requirements
- R1: After reset, every boundary and attribute is zero, the lock is open, `rsp_valid` and `cfg_err` are low, and every access faults.
- R2: An address below boundary0, or greater than or equal to boundary2, is in the reject section and always faults.
- R3: An address in [boundary0, boundary1) is judged by attribute 1, and an address in [boundary1, boundary2) is judged by attribute 2.
- R4: Attribute bit `world*3 + kind` grants the access. The kind encoding is 0 read, 1 write, 2 execute, and the world is 0 or 1. A clear bit faults. Kind 3 always faults.
- R5: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_fault` is low whenever `rsp_valid` is low.
- R6: A boundary set that breaks boundary0 <= boundary1 <= boundary2 is refused while unlocked. The stored boundaries stay unchanged, and `cfg_err` is high for one cycle, in the cycle after the write.
- R7: A boundary set in order is accepted while unlocked, with `cfg_err` low. The new boundaries judge requests from the next cycle on, and an attribute write takes effect in the same way.
- R8: Once the lock is set, boundary writes and attribute writes are ignored. `cfg_err` stays low, even for a set that is out of order.
- R9: Only reset clears the lock. After reset, configuration writes take effect again.
- R10: A write presented in the same cycle as the lock request still takes effect. The lock applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bnd_we | input | 1 | Write the three boundaries |
| cfg_bnd0 | input | ADDR_W | New boundary 0 |
| cfg_bnd1 | input | ADDR_W | New boundary 1 |
| cfg_bnd2 | input | ADDR_W | New boundary 2 |
| cfg_attr_we | input | 1 | Write both section attributes |
| cfg_attr_s1 | input | 6 | New section 1 attribute |
| cfg_attr_s2 | input | 6 | New section 2 attribute |
| cfg_lock_set | input | 1 | Set the sticky lock |
| cfg_err | output | 1 | Invalid-argument pulse for a refused boundary set |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_world | input | 1 | Security world of the access |
| rsp_valid | output | 1 | Verdict present |
| rsp_fault | output | 1 | Access denied |

## Verification
With a 6-bit address, the bench sweeps every address, every kind and both worlds under several boundary sets. These sets include one where section 1 is empty and one where the top boundary sits at the last address, so each sweep separates off-by-one section edges and swapped attributes. A second sweep runs all 64 values of attribute 1 at a fixed address, which checks every bit position of the permission encoding. Write sequences send boundary sets in order and out of order, before and after the lock, and in the same cycle as the lock. The sweeps then show whether the stored configuration changed.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int PERM_PER_WORLD = 3;
  localparam int WORLD_COUNT    = 2;
  localparam int ATTR_BITS      = PERM_PER_WORLD * WORLD_COUNT;

  typedef enum logic [1:0] {
    SEC_REJECT = 2'd0,
    SEC_ONE    = 2'd1,
    SEC_TWO    = 2'd2
  } sect_e;

  // Grant bit lookup: index world*3 + kind, kind 3 never granted.
  function automatic logic perm_granted(input logic [ATTR_BITS-1:0] attr,
                                        input logic [1:0] kind,
                                        input logic world);
    int idx;
    if (kind == 2'd3) return 1'b0;
    idx = int'(world) * PERM_PER_WORLD + int'(kind);
    return attr[idx];
  endfunction
endpackage

// File: rtl/pms_cfg_bank.sv
module pms_cfg_bank #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = pms_pkg::ATTR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_we,
  input  logic [ADDR_W-1:0] bnd0_in,
  input  logic [ADDR_W-1:0] bnd1_in,
  input  logic [ADDR_W-1:0] bnd2_in,
  input  logic              attr_we,
  input  logic [ATTR_W-1:0] attr1_in,
  input  logic [ATTR_W-1:0] attr2_in,
  input  logic              lock_set,
  output logic [ADDR_W-1:0] bnd0_q,
  output logic [ADDR_W-1:0] bnd1_q,
  output logic [ADDR_W-1:0] bnd2_q,
  output logic [ATTR_W-1:0] attr1_q,
  output logic [ATTR_W-1:0] attr2_q,
  output logic              locked_q,
  output logic              bad_bnd_q
);
  logic wr_open, bnd_ordered, bnd_accept, bnd_refuse;

  assign wr_open     = !locked_q;
  assign bnd_ordered = (bnd0_in <= bnd1_in) && (bnd1_in <= bnd2_in);
  assign bnd_accept  = wr_open && bnd_we && bnd_ordered;
  assign bnd_refuse  = wr_open && bnd_we && !bnd_ordered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd0_q    <= '0;
      bnd1_q    <= '0;
      bnd2_q    <= '0;
      attr1_q   <= '0;
      attr2_q   <= '0;
      locked_q  <= 1'b0;
      bad_bnd_q <= 1'b0;
    end else begin
      bad_bnd_q <= bnd_refuse;
      if (lock_set) locked_q <= 1'b1;
      if (bnd_accept) begin
        bnd0_q <= bnd0_in;
        bnd1_q <= bnd1_in;
        bnd2_q <= bnd2_in;
      end
      if (wr_open && attr_we) begin
        attr1_q <= attr1_in;
        attr2_q <= attr2_in;
      end
    end
  end
endmodule

// File: rtl/pms_sect_map.sv
module pms_sect_map #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] bnd0,
  input  logic [ADDR_W-1:0] bnd1,
  input  logic [ADDR_W-1:0] bnd2,
  output pms_pkg::sect_e    sect
);
  always_comb begin
    if (addr < bnd0 || addr >= bnd2) sect = pms_pkg::SEC_REJECT;
    else if (addr < bnd1)            sect = pms_pkg::SEC_ONE;
    else                             sect = pms_pkg::SEC_TWO;
  end
endmodule

// File: rtl/pms_verdict.sv
module pms_verdict #(
  parameter int ATTR_W = pms_pkg::ATTR_BITS
) (
  input  pms_pkg::sect_e    sect,
  input  logic [ATTR_W-1:0] attr1,
  input  logic [ATTR_W-1:0] attr2,
  input  logic [1:0]        kind,
  input  logic              world,
  output logic              allow
);
  always_comb begin
    unique case (sect)
      pms_pkg::SEC_ONE: allow = pms_pkg::perm_granted(attr1, kind, world);
      pms_pkg::SEC_TWO: allow = pms_pkg::perm_granted(attr2, kind, world);
      default:          allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/addr_perm_guard.sv
module addr_perm_guard #(
  parameter int ADDR_W = 32,
  localparam int ATTR_W = pms_pkg::ATTR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bnd_we,
  input  logic [ADDR_W-1:0] cfg_bnd0,
  input  logic [ADDR_W-1:0] cfg_bnd1,
  input  logic [ADDR_W-1:0] cfg_bnd2,
  input  logic              cfg_attr_we,
  input  logic [ATTR_W-1:0] cfg_attr_s1,
  input  logic [ATTR_W-1:0] cfg_attr_s2,
  input  logic              cfg_lock_set,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              req_world,
  output logic              rsp_valid,
  output logic              rsp_fault
);
  logic [ADDR_W-1:0] bnd0_q, bnd1_q, bnd2_q;
  logic [ATTR_W-1:0] attr1_q, attr2_q;
  logic              locked_q;
  pms_pkg::sect_e    req_sect;
  logic              req_allow;

  pms_cfg_bank #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .bnd_we(cfg_bnd_we), .bnd0_in(cfg_bnd0), .bnd1_in(cfg_bnd1), .bnd2_in(cfg_bnd2),
    .attr_we(cfg_attr_we), .attr1_in(cfg_attr_s1), .attr2_in(cfg_attr_s2),
    .lock_set(cfg_lock_set),
    .bnd0_q(bnd0_q), .bnd1_q(bnd1_q), .bnd2_q(bnd2_q),
    .attr1_q(attr1_q), .attr2_q(attr2_q),
    .locked_q(locked_q), .bad_bnd_q(cfg_err)
  );

  pms_sect_map #(.ADDR_W(ADDR_W)) u_map (
    .addr(req_addr), .bnd0(bnd0_q), .bnd1(bnd1_q), .bnd2(bnd2_q), .sect(req_sect)
  );

  pms_verdict #(.ATTR_W(ATTR_W)) u_verdict (
    .sect(req_sect), .attr1(attr1_q), .attr2(attr2_q),
    .kind(req_kind), .world(req_world), .allow(req_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && !req_allow;
    end
  end
endmodule

// File: rtl/pms_guard_chk.sv
module pms_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_bnd_we,
  input logic [ADDR_W-1:0] cfg_bnd0,
  input logic [ADDR_W-1:0] cfg_bnd1,
  input logic [ADDR_W-1:0] cfg_bnd2,
  input logic              cfg_err,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] bnd0_q,
  input logic [ADDR_W-1:0] bnd1_q,
  input logic [ADDR_W-1:0] bnd2_q,
  input logic [ATTR_W-1:0] attr1_q,
  input logic [ATTR_W-1:0] attr2_q,
  input logic              locked_q
);
  // R5
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_fault);
  // R2
  reject_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr < bnd0_q || req_addr >= bnd2_q)) |=> rsp_fault);
  // R6
  bad_set_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bnd_we && !locked_q && !(cfg_bnd0 <= cfg_bnd1 && cfg_bnd1 <= cfg_bnd2))
    |=> cfg_err && $stable(bnd0_q) && $stable(bnd1_q) && $stable(bnd2_q));
  // R6
  stored_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bnd0_q <= bnd1_q && bnd1_q <= bnd2_q);
  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> !cfg_err && $stable(bnd0_q) && $stable(bnd1_q) && $stable(bnd2_q)
                 && $stable(attr1_q) && $stable(attr2_q));
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
endmodule

bind addr_perm_guard pms_guard_chk #(.ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_bnd_we(cfg_bnd_we),
  .cfg_bnd0(cfg_bnd0), .cfg_bnd1(cfg_bnd1), .cfg_bnd2(cfg_bnd2),
  .cfg_err(cfg_err), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .bnd0_q(bnd0_q), .bnd1_q(bnd1_q), .bnd2_q(bnd2_q),
  .attr1_q(attr1_q), .attr2_q(attr2_q), .locked_q(locked_q)
);

// File: tb/test_addr_perm_guard.sv
module test_addr_perm_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_bnd_we = 1'b0, cfg_attr_we = 1'b0, cfg_lock_set = 1'b0;
  logic [AW-1:0] cfg_bnd0 = '0, cfg_bnd1 = '0, cfg_bnd2 = '0;
  logic [5:0] cfg_attr_s1 = '0, cfg_attr_s2 = '0;
  logic cfg_err;
  logic req_valid = 1'b0, req_world = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid, rsp_fault;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;
  int m_b0, m_b1, m_b2, m_a1, m_a2;
  bit m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_perm_guard #(.ADDR_W(AW)) i_addr_perm_guard (
    .clk(clk), .rst_n(rst_n), .cfg_bnd_we(cfg_bnd_we),
    .cfg_bnd0(cfg_bnd0), .cfg_bnd1(cfg_bnd1), .cfg_bnd2(cfg_bnd2),
    .cfg_attr_we(cfg_attr_we), .cfg_attr_s1(cfg_attr_s1), .cfg_attr_s2(cfg_attr_s2),
    .cfg_lock_set(cfg_lock_set), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
    .req_world(req_world), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fault(input int a, input int k, input int w);
    int attr;
    if (a < m_b0 || a >= m_b2) return 1;
    attr = (a < m_b1) ? m_a1 : m_a2;
    if (k == 3) return 1;
    return ((attr >> (w * 3 + k)) & 1) == 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_b0 = 0; m_b1 = 0; m_b2 = 0; m_a1 = 0; m_a2 = 0; m_lock = 0;
  endtask

  task automatic access(input int a, input int k, input int w, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_kind = 2'(k); req_world = w[0];
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R5", int'(rsp_valid), 1);
    check(rsp_fault == exp_fault(a, k, w), req, int'(rsp_fault), int'(exp_fault(a, k, w)));
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < SPAN; a++)
      for (int k = 0; k < 4; k++)
        for (int w = 0; w < 2; w++)
          access(a, k, w, req);
  endtask

  task automatic wr_bnd(input int x, input int y, input int z, input bit with_lock, input string req);
    bit ordered = (x <= y) && (y <= z);
    @(negedge clk);
    cfg_bnd_we = 1'b1; cfg_bnd0 = AW'(x); cfg_bnd1 = AW'(y); cfg_bnd2 = AW'(z);
    cfg_lock_set = with_lock;
    @(negedge clk);
    cfg_bnd_we = 1'b0; cfg_lock_set = 1'b0;
    check(cfg_err == (!m_lock && !ordered), req, int'(cfg_err), int'(!m_lock && !ordered));
    if (!m_lock && ordered) begin m_b0 = x; m_b1 = y; m_b2 = z; end
    if (with_lock) m_lock = 1;
    @(negedge clk);
    check(cfg_err == 1'b0, req, int'(cfg_err), 0);
  endtask

  task automatic wr_attr(input int p, input int q);
    @(negedge clk);
    cfg_attr_we = 1'b1; cfg_attr_s1 = 6'(p); cfg_attr_s2 = 6'(q);
    @(negedge clk);
    cfg_attr_we = 1'b0;
    if (!m_lock) begin m_a1 = p; m_a2 = q; end
  endtask

  task automatic set_lock();
    @(negedge clk);
    cfg_lock_set = 1'b1;
    @(negedge clk);
    cfg_lock_set = 1'b0;
    m_lock = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    check(cfg_err == 1'b0, "R1", int'(cfg_err), 0);
    access(0, 0, 0, "R1");
    access(33, 2, 1, "R1");
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_fault == 1'b0, "R5", int'(rsp_valid), 0);

    // R7, R3, R4: typical split, attributes differ per world/kind
    wr_bnd(8, 24, 48, 0, "R7");
    wr_attr(6'b011_101, 6'b100_010);
    sweep("R3");
    // R2: empty section 1, top boundary at last address
    wr_bnd(20, 20, SPAN - 1, 0, "R7");
    wr_attr(6'b111_111, 6'b010_001);
    sweep("R2");
    // R4: every attribute value in section 1
    wr_bnd(10, 30, 40, 0, "R7");
    for (int v = 0; v < 64; v++) begin
      wr_attr(v, 63 - v);
      for (int k = 0; k < 4; k++)
        for (int w = 0; w < 2; w++) begin
          access(15, k, w, "R4");
          access(35, k, w, "R3");
        end
    end
    // R6: out-of-order sets refused, config unchanged
    wr_bnd(30, 20, 40, 0, "R6");
    wr_bnd(5, 50, 45, 0, "R6");
    wr_bnd(1, 0, 0, 0, "R6");
    sweep("R6");

    // R8: lock, then writes ignored with no error
    wr_attr(6'b110_011, 6'b001_110);
    set_lock();
    wr_bnd(0, 32, 63, 0, "R8");
    wr_bnd(40, 10, 5, 0, "R8");
    wr_attr(6'b111_111, 6'b111_111);
    sweep("R8");

    // R9: reset clears lock, writes work again
    do_reset();
    access(12, 0, 0, "R9");
    wr_bnd(4, 12, 60, 0, "R9");
    wr_attr(6'b000_111, 6'b111_000);
    sweep("R9");

    // R10: write together with lock takes effect
    wr_bnd(2, 16, 50, 1, "R10");
    wr_bnd(0, 1, 2, 0, "R10");
    sweep("R10");

    finish_run();
  end
endmodule